// File: doc/BRIEF.md
# Byte ALU with Carry Status Latch

This block is the arithmetic-logic stage of a microprogrammed storage controller. Each cycle it combines a byte operand A, which arrives with its own odd-parity bit, with a byte operand B. B is used as is or complemented. A three-bit function code picks one of eight operations: four adds that differ in how they treat carry, a latched-carry add, and the bitwise AND, OR and exclusive-OR. A separate select passes A straight onto the result bus without change.

Results are taken only on cycles in which the microprogram raises the commit strobe. On such a cycle the result byte, its generated odd parity and a zero flag are registered onto the D outputs. A one-bit carry status latch holds the carry-out of the operations that keep it, and the latched-carry add reads it back as its carry-in.

Parity is predicted independently of the datapath. The prediction starts from A's incoming parity bit, then takes in B and either a separately built carry chain or the logic function. A mismatch between the prediction and the parity of the produced result sets a sticky error flag, which only reset clears.

Top module: `byte_alu_core`

## Requirements
- R1: After synchronous active-low reset, d_bus is 0x00, d_zero is 1, d_par is 1, carry_flag is 0 and alu_err is 0.
- R2: Function code 3'b000 registers A + B + 0 on a commit and leaves carry_flag unchanged.
- R3: Function code 3'b001 registers A + B + 1 on a commit and leaves carry_flag unchanged.
- R4: Function codes 3'b010, 3'b011 and 3'b111 register A AND B, A OR B and A XOR B respectively, and leave carry_flag unchanged.
- R5: Function codes 3'b100 and 3'b101 register A + B + 0 and A + B + 1 respectively, and load the carry-out of bit 7 into carry_flag.
- R6: Function code 3'b110 registers A + B + carry_flag and loads the new carry-out into carry_flag.
- R7: When b_invert is 1, the bitwise complement of B replaces B in every operation, so code 3'b101 with b_invert yields A - B, with carry_flag 1 meaning no borrow.
- R8: d_zero is 1 exactly when the registered d_bus is 0x00.
- R9: When bypass_a is 1, a commit registers A unchanged on d_bus whatever the function code, and carry_flag is left unchanged.
- R10: d_par is the odd parity of d_bus: d_bus together with d_par has an odd number of ones.
- R11: a_par is odd parity over A. A commit whose a_par disagrees with A makes the predicted parity miss the result parity and sets alu_err. alu_err then stays 1 until reset.
- R12: Outputs and carry_flag change only on a clock edge where commit is 1. Without commit, changes on the inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_opnd | input | 8 | A operand byte |
| a_par | input | 1 | Odd parity bit accompanying a_opnd |
| b_opnd | input | 8 | B operand byte |
| b_invert | input | 1 | Use the complement of b_opnd |
| func | input | 3 | Function code |
| bypass_a | input | 1 | Route A onto the D bus unchanged |
| commit | input | 1 | Register the result and update status this cycle |
| d_bus | output | 8 | Registered result byte |
| d_par | output | 1 | Odd parity of d_bus |
| d_zero | output | 1 | d_bus equals zero |
| carry_flag | output | 1 | Carry status latch |
| alu_err | output | 1 | Sticky parity-prediction error |

## Verification
The bench builds the block with its default byte width of 8. At that width, operand values near 0xFF and 0x80 reach every carry boundary: wrap to zero with carry, carry through the status latch, and borrow and no-borrow in complemented subtraction. A chain of latched-carry operations shows that codes 000 and 001 preserve the flag set by an earlier operation. An operand presented with deliberately wrong parity drives the predictor off the result parity, which shows the error flag setting and then holding across later clean operations until a second reset.

// File: rtl/byte_alu_pkg.sv
// Package: shared function codes and decode helpers for the byte ALU.
// Assumes the function field is three bits wide; codes are fixed by microcode.
package byte_alu_pkg;

    typedef enum logic [2:0] {
        FN_ADD    = 3'b000,
        FN_ADD1   = 3'b001,
        FN_AND    = 3'b010,
        FN_OR     = 3'b011,
        FN_ADDK   = 3'b100,
        FN_ADD1K  = 3'b101,
        FN_ADDC   = 3'b110,
        FN_XOR    = 3'b111
    } alu_fn_e;

    // True for every code that routes through the adder.
    function automatic logic fn_is_add(alu_fn_e f);
        return (f == FN_ADD) || (f == FN_ADD1) || (f == FN_ADDK) ||
               (f == FN_ADD1K) || (f == FN_ADDC);
    endfunction

    // True for codes whose carry-out is kept in the status latch.
    function automatic logic fn_keeps_carry(alu_fn_e f);
        return (f == FN_ADDK) || (f == FN_ADD1K) || (f == FN_ADDC);
    endfunction

endpackage

// File: rtl/alu_datapath.sv
// Module: combinational datapath. It selects B or its complement, picks the
// carry-in, ripples the add, forms logic results and applies the A bypass.
// Assumes carry_flag is the registered status latch value.
module alu_datapath
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         b_inv,
    input  alu_fn_e      fn,
    input  logic         bypass,
    input  logic         carry_flag,
    output logic [W-1:0] b_eff,
    output logic         cin,
    output logic [W-1:0] result,
    output logic         cout
);

    logic [W:0]   chain;
    logic [W-1:0] sum;

    // Operand B conditioning through the complement path.
    always_comb b_eff = b_inv ? ~b : b;

    // Carry-in selection per function code.
    always_comb begin
        unique case (fn)
            FN_ADD1, FN_ADD1K: cin = 1'b1;
            FN_ADDC:           cin = carry_flag;
            default:           cin = 1'b0;
        endcase
    end

    assign chain[0] = cin;

    // Ripple adder, one full-adder cell per bit.
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
    end

    // Result selection: bypass overrides the function code.
    always_comb begin
        cout = 1'b0;
        if (bypass) begin
            result = a;
        end else begin
            unique case (fn)
                FN_AND:  result = a & b_eff;
                FN_OR:   result = a | b_eff;
                FN_XOR:  result = a ^ b_eff;
                default: begin
                    result = sum;
                    cout   = chain[W];
                end
            endcase
        end
    end

endmodule

// File: rtl/alu_parity_predict.sv
// Module: predicts the odd parity of the ALU result from A's incoming parity
// bit, B and the operation, using its own carry chain, independent of the adder.
// Assumes a_par is odd parity over a.
module alu_parity_predict
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         a_par,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    input  alu_fn_e      fn,
    input  logic         bypass,
    output logic         pred_par
);

    logic [W-1:0] cvec;
    logic         a_even;
    logic         pred_even;

    assign a_even  = ~a_par;
    assign cvec[0] = cin;

    // Duplicate carry generation; only carries into bits 0..W-1 are needed.
    for (genvar i = 1; i < W; i++) begin : g_cy
        assign cvec[i] = (a[i-1] & b_eff[i-1]) | (cvec[i-1] & (a[i-1] | b_eff[i-1]));
    end

    // Even-sense parity prediction per operation.
    always_comb begin
        if (bypass) begin
            pred_even = a_even;
        end else if (fn_is_add(fn)) begin
            pred_even = a_even ^ (^b_eff) ^ (^cvec);
        end else begin
            unique case (fn)
                FN_AND:  pred_even = a_even ^ (^(a & ~b_eff));
                FN_OR:   pred_even = a_even ^ (^(~a & b_eff));
                default: pred_even = a_even ^ (^b_eff);
            endcase
        end
        pred_par = ~pred_even;
    end

endmodule

// File: rtl/alu_status.sv
// Module: output and status registers. On commit it captures result, parity
// and zero flag, updates the carry latch for carry-keeping codes and sets the
// sticky parity error. Assumes synchronous active-low reset.
module alu_status
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] result,
    input  logic         cout,
    input  alu_fn_e      fn,
    input  logic         bypass,
    input  logic         pred_par,
    output logic [W-1:0] d_bus,
    output logic         d_par,
    output logic         d_zero,
    output logic         carry_flag,
    output logic         alu_err
);

    logic res_par;
    assign res_par = ~^result;

    // Result bus, parity and zero flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_bus  <= '0;
            d_par  <= 1'b1;
            d_zero <= 1'b1;
        end else if (commit) begin
            d_bus  <= result;
            d_par  <= res_par;
            d_zero <= (result == '0);
        end
    end

    // Carry status latch, loaded only by carry-keeping adds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_flag <= 1'b0;
        else if (commit && !bypass && fn_keeps_carry(fn))
            carry_flag <= cout;
    end

    // Sticky parity-prediction error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alu_err <= 1'b0;
        else if (commit && (pred_par != res_par))
            alu_err <= 1'b1;
    end

    // R12
    hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(d_bus) && $stable(carry_flag) && $stable(d_par)));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_err |=> alu_err);

    // R10
    dbus_odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (d_par == ~^d_bus));

endmodule

// File: rtl/byte_alu_core.sv
// Module: top of the byte ALU. It joins the datapath, the independent parity
// predictor and the status registers. Assumes operands are stable during a
// commit cycle and that a_par is odd parity over a_opnd.
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   a_opnd,
    input  logic         a_par,
    input  logic [7:0]   b_opnd,
    input  logic         b_invert,
    input  logic [2:0]   func,
    input  logic         bypass_a,
    input  logic         commit,
    output logic [7:0]   d_bus,
    output logic         d_par,
    output logic         d_zero,
    output logic         carry_flag,
    output logic         alu_err
);

    alu_fn_e      fn;
    logic [W-1:0] b_eff;
    logic [W-1:0] result;
    logic         cin;
    logic         cout;
    logic         pred_par;

    assign fn = alu_fn_e'(func);

    alu_datapath #(.W(W)) u_dp (
        .a          (a_opnd),
        .b          (b_opnd),
        .b_inv      (b_invert),
        .fn         (fn),
        .bypass     (bypass_a),
        .carry_flag (carry_flag),
        .b_eff      (b_eff),
        .cin        (cin),
        .result     (result),
        .cout       (cout)
    );

    alu_parity_predict #(.W(W)) u_pp (
        .a        (a_opnd),
        .a_par    (a_par),
        .b_eff    (b_eff),
        .cin      (cin),
        .fn       (fn),
        .bypass   (bypass_a),
        .pred_par (pred_par)
    );

    alu_status #(.W(W)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .result     (result),
        .cout       (cout),
        .fn         (fn),
        .bypass     (bypass_a),
        .pred_par   (pred_par),
        .d_bus      (d_bus),
        .d_par      (d_par),
        .d_zero     (d_zero),
        .carry_flag (carry_flag),
        .alu_err    (alu_err)
    );

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_zero == (d_bus == 8'h00));

    // R9
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && bypass_a) |=> (d_bus == $past(a_opnd)));

    // R2
    plain_add_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !bypass_a && func == 3'b000) |=> $stable(carry_flag));

endmodule

// File: tb/byte_alu_core_bench.sv
module byte_alu_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_opnd = '0;
    logic       a_par = 1'b1;
    logic [7:0] b_opnd = '0;
    logic       b_invert = 1'b0;
    logic [2:0] func = '0;
    logic       bypass_a = 1'b0;
    logic       commit = 1'b0;
    logic [7:0] d_bus;
    logic       d_par;
    logic       d_zero;
    logic       carry_flag;
    logic       alu_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    byte_alu_core u_byte_alu_core (
        .clk(clk), .rst_n(rst_n), .a_opnd(a_opnd), .a_par(a_par),
        .b_opnd(b_opnd), .b_invert(b_invert), .func(func),
        .bypass_a(bypass_a), .commit(commit), .d_bus(d_bus), .d_par(d_par),
        .d_zero(d_zero), .carry_flag(carry_flag), .alu_err(alu_err)
    );

    typedef struct {
        string      tag;
        logic [7:0] d;
        logic       cy;
        logic       err;
    } exp_t;

    exp_t scb[$];
    logic cy_m  = 1'b0;
    logic err_m = 1'b0;
    logic cap   = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one committed operation and queues its expected outcome.
    task automatic op(string tag, logic [7:0] a, logic [7:0] b, logic inv,
                      logic [2:0] fn, logic byp, logic bad_par);
        exp_t       e;
        logic [7:0] be;
        logic       ci;
        logic [8:0] s;
        be = inv ? ~b : b;
        ci = (fn == 3'b001 || fn == 3'b101) ? 1'b1 : (fn == 3'b110) ? cy_m : 1'b0;
        s  = {1'b0, a} + {1'b0, be} + {8'b0, ci};
        if (byp)                  e.d = a;
        else if (fn == 3'b010)    e.d = a & be;
        else if (fn == 3'b011)    e.d = a | be;
        else if (fn == 3'b111)    e.d = a ^ be;
        else                      e.d = s[7:0];
        if (!byp && (fn == 3'b100 || fn == 3'b101 || fn == 3'b110)) cy_m = s[8];
        if (bad_par) err_m = 1'b1;
        e.cy = cy_m; e.err = err_m; e.tag = tag;
        @(negedge clk);
        a_opnd = a; b_opnd = b; b_invert = inv; func = fn; bypass_a = byp;
        a_par = bad_par ? (^a) : ~(^a);
        commit = 1'b1;
        scb.push_back(e);
        @(negedge clk);
        commit = 1'b0;
    endtask

    always @(posedge clk) cap <= commit;

    // Monitor: compares each committed result at the falling edge after capture.
    always @(negedge clk) begin
        if (cap && scb.size() > 0) begin
            exp_t e;
            e = scb.pop_front();
            chk({e.tag, " d_bus"}, {24'b0, d_bus}, {24'b0, e.d});
            chk({e.tag, " carry_flag"}, {31'b0, carry_flag}, {31'b0, e.cy});
            chk({e.tag, " R8 d_zero"}, {31'b0, d_zero}, {31'b0, (e.d == 8'h00)});
            chk({e.tag, " R10 d_par"}, {31'b0, d_par}, {31'b0, ~^e.d});
            chk({e.tag, " R11 alu_err"}, {31'b0, alu_err}, {31'b0, e.err});
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cy_m = 1'b0; err_m = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        chk("R1 d_bus", {24'b0, d_bus}, 32'h00);
        chk("R1 d_zero", {31'b0, d_zero}, 32'h1);
        chk("R1 d_par", {31'b0, d_par}, 32'h1);
        chk("R1 carry_flag", {31'b0, carry_flag}, 32'h0);
        chk("R1 alu_err", {31'b0, alu_err}, 32'h0);

        op("R2 add",          8'h3C, 8'h05, 1'b0, 3'b000, 1'b0, 1'b0);
        op("R5 add keep cy",  8'hF0, 8'h20, 1'b0, 3'b100, 1'b0, 1'b0);
        op("R2 add wraps cy held", 8'hFF, 8'h01, 1'b0, 3'b000, 1'b0, 1'b0);
        op("R6 add with cy",  8'h10, 8'h01, 1'b0, 3'b110, 1'b0, 1'b0);
        op("R5 add1 keep cy", 8'hFF, 8'h00, 1'b0, 3'b101, 1'b0, 1'b0);
        op("R6 cy chain",     8'h7F, 8'h80, 1'b0, 3'b110, 1'b0, 1'b0);
        op("R3 add1 cy held", 8'h20, 8'h0F, 1'b0, 3'b001, 1'b0, 1'b0);
        op("R4 and",          8'hCA, 8'h6C, 1'b0, 3'b010, 1'b0, 1'b0);
        op("R4 or",           8'hCA, 8'h6C, 1'b0, 3'b011, 1'b0, 1'b0);
        op("R4 xor",          8'hCA, 8'h6C, 1'b0, 3'b111, 1'b0, 1'b0);
        op("R7 sub no borrow", 8'h50, 8'h30, 1'b1, 3'b101, 1'b0, 1'b0);
        op("R7 sub borrow",   8'h30, 8'h50, 1'b1, 3'b101, 1'b0, 1'b0);
        op("R7 and inverted", 8'hF3, 8'h0F, 1'b1, 3'b010, 1'b0, 1'b0);
        op("R5 set cy",       8'h80, 8'h80, 1'b0, 3'b100, 1'b0, 1'b0);
        op("R9 bypass",       8'h9D, 8'h44, 1'b0, 3'b110, 1'b1, 1'b0);
        op("R8 zero and",     8'hAA, 8'h55, 1'b0, 3'b010, 1'b0, 1'b0);

        // R12: inputs move without commit; outputs must hold.
        @(negedge clk);
        a_opnd = 8'h11; b_opnd = 8'hEE; func = 3'b100; bypass_a = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 d_bus hold", {24'b0, d_bus}, 32'h00);
        chk("R12 carry hold", {31'b0, carry_flag}, {31'b0, cy_m});

        op("R11 bad parity",  8'h01, 8'h02, 1'b0, 3'b111, 1'b0, 1'b1);
        op("R11 err sticky",  8'h05, 8'h06, 1'b0, 3'b000, 1'b0, 1'b0);
        op("R11 bad parity add", 8'h33, 8'h11, 1'b0, 3'b100, 1'b0, 1'b1);
        @(negedge clk);

        do_reset();
        chk("R11 err cleared by reset", {31'b0, alu_err}, 32'h0);
        chk("R1 carry after reset", {31'b0, carry_flag}, 32'h0);
        op("R11 bad parity and", 8'h0F, 8'hF1, 1'b0, 3'b010, 1'b0, 1'b1);
        op("R11 bad parity bypass", 8'h07, 8'h00, 1'b0, 3'b000, 1'b1, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk("R1 queue drained", scb.size(), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule